// File: doc/BRIEF.md
# Expansion Bus Read-Cycle Controller

This block turns host read requests into read cycles on an external static-memory and expansion bus. A request gives a start address, a beat count, a chip-select index and an access size. The controller asserts one active-low chip select and the active-low output enable, and presents the address and a size flag. It captures the returned data and hands each beat back with a one-cycle valid pulse. A done pulse follows the final beat.

Each beat's strobe has a minimum length of one clock. A programmed wait-state count adds whole clocks to it, and so does an external ready line that is synchronised on the falling clock edge. Every chip select has its own configuration: a non-sequential wait count, a sequential wait count and a sequential-access enable. In a multi-beat burst the strobes stay low from the first address to the last. Separate single reads each get their own strobe assertion. With sequential access disabled, one extra idle clock is placed between them.

Top module: `exp_read_ctrl`

## Requirements
- R1: While reset is asserted, every chip select and the output enable are high, and the valid and done outputs are low.
- R2: `reqAck` is high in the same cycle as `reqValid` whenever the controller is idle. From the next cycle, `busOeN` is low and `busCsN` bit i is the only low bit, where i is `reqCs`. During that cycle `busAddr` equals `reqAddr` and `busWord` equals `reqWord`.
- R3: With ready high, the first beat's strobe lasts wsNseq+1 cycles. wsNseq is the 2-bit field at bits [2i+1:2i] of `cfgWsNseq` for the selected chip select. At the last edge of the beat, the bus data is captured. `rdValid` is high with that data in the following cycle.
- R4: Each later beat of a burst lasts wsSeq+1 cycles if `cfgSeqEn[i]` is 1, and wsNseq+1 cycles otherwise. wsSeq is taken from `cfgWsSeq[2i+1:2i]`.
- R5: After each beat that is not the last, `busAddr` steps by 4 when `busWord` is 1, and by 1 when it is 0.
- R6: Within a burst, the chip select and output enable stay low across every beat. They go high in the cycle after the last capture.
- R7: `rdDone` pulses for one cycle, one cycle after the last `rdValid` of a request.
- R8: `busRdy` passes through two falling-edge flops. While the synchronised value is low at the data point, the beat stretches one clock at a time. If `busRdy` rises just after a rising edge during a stall, the capture happens on the second rising edge after that.
- R9: With sequential access enabled, a pending request is accepted in the first cycle after a request's last capture, so the strobes are high for exactly one cycle. With it disabled, the strobes are high for two cycles.
- R10: Only the configuration fields of the selected chip select affect the timing. The other chip selects' fields have no effect.
- R11: `reqAck` stays low while a read is in progress and during the idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Read request pending |
| reqAck | output | 1 | Request accepted this cycle |
| reqAddr | input | ADDR_W | Start address |
| reqBeats | input | BEAT_W | Number of beats minus one |
| reqCs | input | CS_W | Target chip-select index |
| reqWord | input | 1 | 1 = 32-bit word, 0 = byte |
| cfgSeqEn | input | NUM_CS | Sequential-access enable per chip select |
| cfgWsNseq | input | NUM_CS*WS_W | Non-sequential wait states per chip select |
| cfgWsSeq | input | NUM_CS*WS_W | Sequential wait states per chip select |
| rdData | output | DATA_W | Captured beat data |
| rdValid | output | 1 | One-cycle pulse per captured beat |
| rdDone | output | 1 | Pulse after the final beat |
| busCsN | output | NUM_CS | Active-low chip selects |
| busOeN | output | 1 | Active-low output enable |
| busAddr | output | ADDR_W | Bus address |
| busWord | output | 1 | Access size flag |
| busData | input | DATA_W | Read data from the device |
| busRdy | input | 1 | Asynchronous device ready |

## Verification
Counting from the accepting edge, the strobes are low for samples 1 to S, where S = (wsNseq+1) + beats·(eff+1). Beat b's data is due in the sample after its closing edge, and done is due at sample S+2. The bench therefore samples one nanosecond after each rising edge and compares every cycle against these counts. A change of ready is due two rising edges after it is driven, and the stall test checks both the edge before it and the edge at which it lands. The back-to-back test counts the high-strobe cycles and the acknowledge at the exact cycle R9 predicts.

// File: rtl/exb_rd_pkg.sv
package exb_rd_pkg;

  typedef enum logic [1:0] {
    RD_IDLE   = 2'd0,
    RD_STROBE = 2'd1,
    RD_GAP    = 2'd2
  } rdState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // request accepted this edge
    logic active;   // bus strobes asserted
    logic capture;  // data sampled this edge
    logic advance;  // move to next beat
    logic last;     // final beat captured
  } rdStrobe_t;

endpackage

// File: rtl/exb_rdy_sync.sv
module exb_rdy_sync (
  input  logic clk,
  input  logic rstN,
  input  logic rdyIn,
  output logic rdySync
);
  logic stage1;

  // falling-edge two-flop synchroniser
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1  <= 1'b0;
      rdySync <= 1'b0;
    end else begin
      stage1  <= rdyIn;
      rdySync <= stage1;
    end
  end
endmodule

// File: rtl/exb_rd_ctrl.sv
module exb_rd_ctrl
  import exb_rd_pkg::*;
#(
  parameter int NUM_CS = 6,
  parameter int WS_W   = 2,
  parameter int BEAT_W = 3,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  input  logic [BEAT_W-1:0]      reqBeats,
  input  logic [CS_W-1:0]        reqCs,
  input  logic [NUM_CS-1:0]      cfgSeqEn,
  input  logic [NUM_CS*WS_W-1:0] cfgWsNseq,
  input  logic [NUM_CS*WS_W-1:0] cfgWsSeq,
  input  logic                   rdySync,
  output logic                   reqAck,
  output rdStrobe_t              strb
);
  rdState_t          state;
  logic [WS_W-1:0]   waitCnt;
  logic [BEAT_W-1:0] beatsLeft;
  logic              seqEnL;
  logic [WS_W-1:0]   wsNL, wsSL;

  logic              selSeqEn;
  logic [WS_W-1:0]   selWsN, selWsS;
  logic              dataPoint;

  // pick the configuration of the addressed chip select
  always_comb begin
    selSeqEn = 1'b0;
    selWsN   = '0;
    selWsS   = '0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (reqCs == CS_W'(i)) begin
        selSeqEn = cfgSeqEn[i];
        selWsN   = cfgWsNseq[i*WS_W +: WS_W];
        selWsS   = cfgWsSeq[i*WS_W +: WS_W];
      end
    end
  end

  always_comb begin
    strb.load    = (state == RD_IDLE) && reqValid;
    strb.active  = (state == RD_STROBE);
    dataPoint    = strb.active && (waitCnt == '0);
    strb.capture = dataPoint && rdySync;
    strb.last    = strb.capture && (beatsLeft == '0);
    strb.advance = strb.capture && (beatsLeft != '0);
    reqAck       = strb.load;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= RD_IDLE;
      waitCnt   <= '0;
      beatsLeft <= '0;
      seqEnL    <= 1'b0;
      wsNL      <= '0;
      wsSL      <= '0;
    end else begin
      case (state)
        RD_IDLE: begin
          if (strb.load) begin
            state     <= RD_STROBE;
            waitCnt   <= selWsN;
            beatsLeft <= reqBeats;
            seqEnL    <= selSeqEn;
            wsNL      <= selWsN;
            wsSL      <= selWsS;
          end
        end
        RD_STROBE: begin
          if (waitCnt != '0) begin
            waitCnt <= waitCnt - 1'b1;
          end else if (strb.advance) begin
            beatsLeft <= beatsLeft - 1'b1;
            waitCnt   <= seqEnL ? wsSL : wsNL;
          end else if (strb.last) begin
            state <= seqEnL ? RD_IDLE : RD_GAP;
          end
        end
        RD_GAP:  state <= RD_IDLE;
        default: state <= RD_IDLE;
      endcase
    end
  end

  // wait states keep the strobe alive
  assert_min_wait_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == RD_STROBE && waitCnt != '0) |=> (state == RD_STROBE));

  // a low ready holds the beat in place
  assert_ready_stall_R8: assert property (@(posedge clk) disable iff (!rstN)
    (dataPoint && !rdySync) |=> (state == RD_STROBE && $stable(beatsLeft)));

  // idle gap only when sequential access is off
  assert_gap_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.last && !seqEnL) |=> (state == RD_GAP));

  assert_no_gap_R9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.last && seqEnL) |=> (state == RD_IDLE));
endmodule

// File: rtl/exb_rd_datapath.sv
module exb_rd_datapath
  import exb_rd_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int DATA_W = 32,
  parameter int NUM_CS = 6,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdStrobe_t         strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CS_W-1:0]   reqCs,
  input  logic              reqWord,
  input  logic [DATA_W-1:0] busData,
  output logic [NUM_CS-1:0] busCsN,
  output logic              busOeN,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busWord,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              rdDone
);
  logic [CS_W-1:0]   csQ;
  logic              doneQ;
  logic [ADDR_W-1:0] addrStep;

  assign addrStep = busWord ? ADDR_W'(4) : ADDR_W'(1);
  assign busOeN   = !strb.active;

  for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
    assign busCsN[i] = !(strb.active && (csQ == CS_W'(i)));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busAddr <= '0;
      csQ     <= '0;
      busWord <= 1'b0;
      rdData  <= '0;
      rdValid <= 1'b0;
      doneQ   <= 1'b0;
      rdDone  <= 1'b0;
    end else begin
      if (strb.load) begin
        busAddr <= reqAddr;
        csQ     <= reqCs;
        busWord <= reqWord;
      end else if (strb.advance) begin
        busAddr <= busAddr + addrStep;
      end
      if (strb.capture) rdData <= busData;
      rdValid <= strb.capture;
      doneQ   <= strb.last;
      rdDone  <= doneQ;
    end
  end

  assert_one_cs_R2: assert property (@(posedge clk) disable iff (!rstN)
    !busOeN |-> ($countones(~busCsN) == 1));

  assert_idle_cs_R1: assert property (@(posedge clk) disable iff (!rstN)
    busOeN |-> (&busCsN));

  assert_burst_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |=> (!busOeN && $stable(busCsN)));

  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.advance |=> (busAddr == $past(busAddr) + ($past(busWord) ? ADDR_W'(4) : ADDR_W'(1))));

  assert_done_follows_R7: assert property (@(posedge clk) disable iff (!rstN)
    rdDone |-> $past(rdValid));
endmodule

// File: rtl/exp_read_ctrl.sv
module exp_read_ctrl
  import exb_rd_pkg::*;
#(
  parameter int ADDR_W = 28,
  parameter int DATA_W = 32,
  parameter int NUM_CS = 6,
  parameter int WS_W   = 2,
  parameter int BEAT_W = 3,
  localparam int CS_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  output logic                   reqAck,
  input  logic [ADDR_W-1:0]      reqAddr,
  input  logic [BEAT_W-1:0]      reqBeats,
  input  logic [CS_W-1:0]        reqCs,
  input  logic                   reqWord,
  input  logic [NUM_CS-1:0]      cfgSeqEn,
  input  logic [NUM_CS*WS_W-1:0] cfgWsNseq,
  input  logic [NUM_CS*WS_W-1:0] cfgWsSeq,
  output logic [DATA_W-1:0]      rdData,
  output logic                   rdValid,
  output logic                   rdDone,
  output logic [NUM_CS-1:0]      busCsN,
  output logic                   busOeN,
  output logic [ADDR_W-1:0]      busAddr,
  output logic                   busWord,
  input  logic [DATA_W-1:0]      busData,
  input  logic                   busRdy
);
  rdStrobe_t strb;
  logic      rdySync;

  exb_rdy_sync u_sync (
    .clk(clk), .rstN(rstN), .rdyIn(busRdy), .rdySync(rdySync)
  );

  exb_rd_ctrl #(.NUM_CS(NUM_CS), .WS_W(WS_W), .BEAT_W(BEAT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqBeats(reqBeats),
    .reqCs(reqCs), .cfgSeqEn(cfgSeqEn), .cfgWsNseq(cfgWsNseq),
    .cfgWsSeq(cfgWsSeq), .rdySync(rdySync), .reqAck(reqAck), .strb(strb)
  );

  exb_rd_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CS(NUM_CS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr), .reqCs(reqCs),
    .reqWord(reqWord), .busData(busData), .busCsN(busCsN), .busOeN(busOeN),
    .busAddr(busAddr), .busWord(busWord), .rdData(rdData),
    .rdValid(rdValid), .rdDone(rdDone)
  );

  // no acceptance while the bus strobe is out
  assert_busy_no_ack_R11: assert property (@(posedge clk) disable iff (!rstN)
    reqAck |-> busOeN);
endmodule

// File: tb/tb_exp_read_ctrl.sv
`timescale 1ns/1ps
module tb_exp_read_ctrl;
  localparam int ADDR_W = 28;
  localparam int DATA_W = 32;
  localparam int NUM_CS = 6;
  localparam int WS_W   = 2;
  localparam int BEAT_W = 3;
  localparam int CS_W   = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                   rstN, reqValid, reqAck, reqWord;
  logic [ADDR_W-1:0]      reqAddr, busAddr;
  logic [BEAT_W-1:0]      reqBeats;
  logic [CS_W-1:0]        reqCs;
  logic [NUM_CS-1:0]      cfgSeqEn, busCsN;
  logic [NUM_CS*WS_W-1:0] cfgWsNseq, cfgWsSeq;
  logic [DATA_W-1:0]      rdData, busData;
  logic                   rdValid, rdDone, busOeN, busWord, busRdy;

  int checks = 0;
  int fails  = 0;

  function automatic logic [DATA_W-1:0] memVal(input logic [ADDR_W-1:0] a);
    return {4'h6, a} ^ 32'h0137_9BDF;
  endfunction

  assign busData = memVal(busAddr);

  exp_read_ctrl dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAck(reqAck),
    .reqAddr(reqAddr), .reqBeats(reqBeats), .reqCs(reqCs), .reqWord(reqWord),
    .cfgSeqEn(cfgSeqEn), .cfgWsNseq(cfgWsNseq), .cfgWsSeq(cfgWsSeq),
    .rdData(rdData), .rdValid(rdValid), .rdDone(rdDone), .busCsN(busCsN),
    .busOeN(busOeN), .busAddr(busAddr), .busWord(busWord),
    .busData(busData), .busRdy(busRdy)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // target CS gets the tested fields, every other CS the opposite ones (R10)
  task automatic setCfg(input int cs, input bit seqEn, input int wsN, input int wsS);
    for (int i = 0; i < NUM_CS; i++) begin
      cfgSeqEn[i]             = (i == cs) ? seqEn : ~seqEn;
      cfgWsNseq[i*WS_W +: WS_W] = (i == cs) ? WS_W'(wsN) : WS_W'(3 - wsN);
      cfgWsSeq[i*WS_W +: WS_W]  = (i == cs) ? WS_W'(wsS) : WS_W'(3 - wsS);
    end
  endtask

  // entered and left one ns after a rising edge
  task automatic runRead(input int cs, input logic [ADDR_W-1:0] a, input int beatsM1,
                         input bit word, input bit seqEn, input int wsN, input int wsS);
    int wsE, S, inc, b, kk, bb;
    bit isEnd;
    logic [NUM_CS-1:0] csExp;
    setCfg(cs, seqEn, wsN, wsS);
    reqCs = CS_W'(cs); reqAddr = a; reqBeats = BEAT_W'(beatsM1);
    reqWord = word; reqValid = 1'b1;
    #1 chk("R2", "reqAck idle", 64'(reqAck), 64'd1);
    @(posedge clk); #1;
    reqValid = 1'b0;
    wsE = seqEn ? wsS : wsN;
    S   = (wsN + 1) + beatsM1 * (wsE + 1);
    inc = word ? 4 : 1;
    csExp = ~(NUM_CS'(1) << cs);
    for (int k = 1; k <= S + 2; k++) begin
      if (k > 1) begin @(posedge clk); #1; end
      if (k <= S) begin
        b = (k <= wsN + 1) ? 0 : 1 + (k - (wsN + 1) - 1) / (wsE + 1);
        chk("R6", "busOeN low in burst", 64'(busOeN), 64'd0);
        chk("R10", "busCsN select", 64'(busCsN), 64'(csExp));
        chk("R5", "busAddr", 64'(busAddr), 64'(ADDR_W'(a + ADDR_W'(b * inc))));
        chk("R2", "busWord", 64'(busWord), 64'(word));
        chk("R11", "reqAck busy", 64'(reqAck), 64'd0);
      end else begin
        chk("R6", "busOeN high after", 64'(busOeN), 64'd1);
        chk("R6", "busCsN high after", 64'(busCsN), 64'({NUM_CS{1'b1}}));
      end
      kk = k - 1;
      isEnd = (kk == wsN + 1) ||
              (kk > wsN + 1 && kk <= S && ((kk - (wsN + 1)) % (wsE + 1)) == 0);
      bb = (kk <= wsN + 1) ? 0 : (kk - (wsN + 1)) / (wsE + 1);
      chk(bb == 0 ? "R3" : "R4", "rdValid", 64'(rdValid), 64'(isEnd));
      if (isEnd)
        chk(bb == 0 ? "R3" : "R4", "rdData", 64'(rdData),
            64'(memVal(ADDR_W'(a + ADDR_W'(bb * inc)))));
      chk("R7", "rdDone", 64'(rdDone), 64'(k == S + 2));
    end
  endtask

  // continuous single reads: count strobe-high cycles
  task automatic backToBack(input bit seqEn);
    setCfg(2, seqEn, 1, 0);
    reqCs = 3'd2; reqAddr = 28'h0000_100; reqBeats = '0; reqWord = 1'b1; reqValid = 1'b1;
    @(posedge clk); #1;
    chk("R9", "k1 strobe", 64'(busOeN), 64'd0);
    @(posedge clk); #1;
    chk("R9", "k2 strobe", 64'(busOeN), 64'd0);
    chk("R11", "k2 ack", 64'(reqAck), 64'd0);
    @(posedge clk); #1;
    chk("R9", "k3 high", 64'(busOeN), 64'd1);
    chk("R9", "k3 ack", 64'(reqAck), 64'(seqEn));
    @(posedge clk); #1;
    chk("R9", "k4 strobe", 64'(busOeN), 64'(!seqEn));
    if (!seqEn) begin
      chk("R9", "k4 ack", 64'(reqAck), 64'd1);
      @(posedge clk); #1;
      chk("R9", "k5 strobe", 64'(busOeN), 64'd0);
    end
    reqValid = 1'b0;
    repeat (6) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int run;
    rstN = 1'b0; reqValid = 1'b0; reqAddr = '0; reqBeats = '0; reqCs = '0;
    reqWord = 1'b0; busRdy = 1'b1;
    setCfg(0, 1'b0, 0, 0);
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "reset busOeN", 64'(busOeN), 64'd1);
    chk("R1", "reset busCsN", 64'(busCsN), 64'({NUM_CS{1'b1}}));
    chk("R1", "reset rdValid", 64'(rdValid), 64'd0);
    chk("R1", "reset rdDone", 64'(rdDone), 64'd0);
    rstN = 1'b1;
    repeat (3) @(posedge clk);
    #1;

    run = 0;
    for (int se = 0; se < 2; se++)
      for (int wn = 0; wn < 4; wn++)
        for (int ws = 0; ws < 4; ws++)
          for (int bt = 0; bt < 4; bt++) begin
            runRead(run % NUM_CS, ADDR_W'(28'h0FF_FF00 + run * 37), bt,
                    run[0], se[0], wn, ws);
            run++;
          end

    backToBack(1'b1);
    backToBack(1'b0);

    // ready stall: R8
    setCfg(1, 1'b0, 1, 0);
    busRdy = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    reqCs = 3'd1; reqAddr = 28'h0000_040; reqBeats = '0; reqWord = 1'b1; reqValid = 1'b1;
    @(posedge clk); #1;
    reqValid = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      if (k > 1) begin @(posedge clk); #1; end
      chk("R8", "stall strobe", 64'(busOeN), 64'd0);
      chk("R8", "stall no valid", 64'(rdValid), 64'd0);
    end
    busRdy = 1'b1;
    @(posedge clk); #1;
    chk("R8", "one edge after ready", 64'(rdValid), 64'd0);
    chk("R8", "strobe still low", 64'(busOeN), 64'd0);
    @(posedge clk); #1;
    chk("R8", "second edge valid", 64'(rdValid), 64'd1);
    chk("R8", "second edge data", 64'(rdData), 64'(memVal(28'h0000_040)));
    chk("R8", "strobe released", 64'(busOeN), 64'd1);
    repeat (4) @(posedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule